// File: doc/BRIEF.md
# Instruction Fetch Stage with Relative Branch

This block keeps the program counter of a single-cycle processor and delivers the instruction stored at that address. Instruction memory is a small word array with a combinational read, so the instruction word follows the program counter within the same cycle. A write port fills the array before a program runs.

At each rising clock edge the program counter takes one of two values. The first is the address of the following word. The second is a branch target relative to the current instruction. The `pc_src` select input picks between them. The branch decision comes from control logic outside the block, which drives `pc_src` and presents the 16-bit word offset taken from the instruction.

Top module: `ifetch_unit`

## Requirements
- R1: A synchronous reset sets `pc_out` to 0x00000000 at the rising edge where `rst` is high. Reset overrides `pc_src` and `br_offset`.
- R2: When `rst` is low and `pc_src` is 0, `pc_out` after the edge equals its previous value plus 4. `br_offset` has no effect.
- R3: When `rst` is low and `pc_src` is 1, `pc_out` after the edge equals the previous value plus 4 plus four times `br_offset`. An offset of 12 gives a step of 52.
- R4: `br_offset` is a two's-complement word count sign-extended from bit 15. An offset of 0xFFFF leaves the PC unchanged, and 0x8000 moves it back by 0x1FFFC bytes.
- R5: `instr_out` equals the memory word at index `pc_out[7:2]` in the same cycle as `pc_out`. Addresses above 255 alias onto the 64 words.
- R6: When `ld_en` is 1 at a rising edge, word `ld_addr` takes `ld_data`. When `ld_en` is 0, no word changes.
- R7: Program counter arithmetic wraps modulo 2^32.
- R8: `pc_out[1:0]` is always 0 outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_src | input | 1 | 1 selects the branch target, 0 the next word |
| br_offset | input | 16 | Signed branch offset in words |
| ld_en | input | 1 | Instruction memory write enable |
| ld_addr | input | 6 | Word index written |
| ld_data | input | 32 | Word written |
| pc_out | output | 32 | Current program counter |
| instr_out | output | 32 | Instruction at the current program counter |

## Verification
Each new program counter is due exactly one rising edge after `pc_src` and `br_offset` are presented. `instr_out` is due in the same cycle as the PC it belongs to, with no register in its path. A word written through the load port can be read from the first cycle after its edge. The bench changes inputs on falling edges and samples on the following falling edge, so that every check falls one register stage after its stimulus.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int XLEN = 32;
  localparam int OFFW = 16;
  localparam int WORD_BYTES = 4;

  typedef logic [XLEN-1:0] addr_t;
  typedef logic [OFFW-1:0] off_t;

  // address of the following word
  function automatic addr_t seq_next(input addr_t pc);
    return pc + addr_t'(WORD_BYTES);
  endfunction

  // word offset widened with its sign and scaled to bytes
  function automatic addr_t off_bytes(input off_t off);
    addr_t wide;
    wide = {{(XLEN-OFFW){off[OFFW-1]}}, off};
    return wide << 2;
  endfunction

  // relative target, measured from the following word
  function automatic addr_t branch_next(input addr_t pc, input off_t off);
    return seq_next(pc) + off_bytes(off);
  endfunction
endpackage

// File: rtl/ifetch_next_pc.sv
module ifetch_next_pc
  import ifetch_pkg::*;
(
  input  addr_t pc_cur,
  input  logic  pc_src,
  input  off_t  br_offset,
  output addr_t seq_pc,
  output addr_t tgt_pc,
  output addr_t pc_nxt
);
  always_comb begin
    seq_pc = seq_next(pc_cur);
    tgt_pc = branch_next(pc_cur, br_offset);
    pc_nxt = pc_src ? tgt_pc : seq_pc;
  end
endmodule

// File: rtl/ifetch_pc_reg.sv
module ifetch_pc_reg
  import ifetch_pkg::*;
#(
  parameter addr_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  addr_t pc_nxt,
  output addr_t pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_nxt;
  end
endmodule

// File: rtl/ifetch_imem.sv
module ifetch_imem
  import ifetch_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_word,
  input  logic [AW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_word
);
  logic [XLEN-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_word;
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifetch_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_src,
  input  logic [OFFW-1:0] br_offset,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] instr_out
);
  // named internal events for the checker
  addr_t seq_pc;
  addr_t tgt_pc;
  addr_t pc_nxt;
  addr_t pc_q;
  logic [AW-1:0] fetch_idx;

  ifetch_next_pc u_next (
    .pc_cur   (pc_q),
    .pc_src   (pc_src),
    .br_offset(br_offset),
    .seq_pc   (seq_pc),
    .tgt_pc   (tgt_pc),
    .pc_nxt   (pc_nxt)
  );

  ifetch_pc_reg #(.RESET_PC('0)) u_pc (
    .clk   (clk),
    .rst   (rst),
    .pc_nxt(pc_nxt),
    .pc_q  (pc_q)
  );

  assign fetch_idx = pc_q[AW+1:2];

  ifetch_imem #(.DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .wr_en  (ld_en),
    .wr_idx (ld_addr),
    .wr_word(ld_data),
    .rd_idx (fetch_idx),
    .rd_word(instr_out)
  );

  assign pc_out = pc_q;
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk
  import ifetch_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            pc_src,
  input logic [OFFW-1:0] br_offset,
  input logic [XLEN-1:0] pc_out,
  input logic [XLEN-1:0] tgt_pc,
  input logic [XLEN-1:0] seq_pc
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (pc_out == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_src |=> (pc_out == $past(seq_pc)));

  // R3
  branch_step_chk: assert property (@(posedge clk) disable iff (rst)
    pc_src |=> (pc_out == $past(tgt_pc)));

  // R4
  offset_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_src && br_offset[OFFW-1]) |=> ((pc_out - $past(pc_out)) != 32'd4
                                        || $past(br_offset) == '0));

  // R8
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc_out[1:0] == 2'b00);
endmodule

bind ifetch_unit ifetch_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc_src   (pc_src),
  .br_offset(br_offset),
  .pc_out   (pc_out),
  .tgt_pc   (tgt_pc),
  .seq_pc   (seq_pc)
);

// File: tb/tb_ifetch_unit.sv
module tb_ifetch_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        pc_src;
  logic [15:0] br_offset;
  logic        ld_en;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_out;
  logic [31:0] instr_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ifetch_unit dut (
    .clk(clk), .rst(rst), .pc_src(pc_src), .br_offset(br_offset),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_out(pc_out), .instr_out(instr_out)
  );

  // {pc_src, br_offset, expected byte step}
  localparam logic [48:0] VECS [0:7] = '{
    {1'b0, 16'h0000, 32'd4},
    {1'b0, 16'h1234, 32'd4},
    {1'b1, 16'h000C, 32'd52},
    {1'b1, 16'hFFFF, 32'd0},
    {1'b1, 16'hFFFD, 32'hFFFF_FFF8},
    {1'b1, 16'h0040, 32'd260},
    {1'b1, 16'h8000, 32'hFFFE_0004},
    {1'b1, 16'h7FFF, 32'h0002_0000}
  };

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return 32'hBEEF_0000 | {26'd0, a[7:2]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp_pc;
    rst = 1'b1; pc_src = 1'b1; br_offset = 16'd100;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    @(negedge clk);
    // R6 preload under reset
    for (int i = 0; i < 64; i++) begin
      ld_en = 1'b1; ld_addr = 6'(i); ld_data = 32'hBEEF_0000 | i;
      tick();
    end
    ld_en = 1'b0;
    // R1 reset holds the PC at zero despite a branch request
    check("R1 reset pc", pc_out, 32'h0);
    check("R5 reset instr", instr_out, word_of(32'h0));

    rst = 1'b0;
    exp_pc = 32'h0;
    // R2 R3 R4 R7 R5 table walk
    for (int v = 0; v < 8; v++) begin
      pc_src = VECS[v][48];
      br_offset = VECS[v][47:32];
      exp_pc = exp_pc + VECS[v][31:0];
      tick();
      check(VECS[v][48] ? "R3/R4/R7 branch pc" : "R2 seq pc", pc_out, exp_pc);
      check("R5 instr", instr_out, word_of(exp_pc));
    end
    // R7 walk ends after wrapping past 2^32
    check("R7 wrap", pc_out, 32'h0000_013C);

    // R1 reset in mid-run
    rst = 1'b1; pc_src = 1'b1; br_offset = 16'h0005;
    tick();
    check("R1 mid reset", pc_out, 32'h0);
    rst = 1'b0;

    // R6 write at current index, R4 offset -1 holds the PC
    pc_src = 1'b1; br_offset = 16'hFFFF;
    ld_en = 1'b1; ld_addr = 6'd0; ld_data = 32'h1234_5678;
    check("R6 before write", instr_out, word_of(32'h0));
    tick();
    check("R4 hold pc", pc_out, 32'h0);
    check("R6 written", instr_out, 32'h1234_5678);

    // R6 disabled write leaves the word unchanged
    ld_en = 1'b0; ld_data = 32'hDEAD_BEEF;
    tick();
    check("R6 no write", instr_out, 32'h1234_5678);

    // R2 offset ignored on sequential step
    pc_src = 1'b0; br_offset = 16'h8000;
    tick();
    check("R2 ignore offset", pc_out, 32'h4);
    check("R5 next word", instr_out, word_of(32'h4));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule